// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the general registers of a 32-bit load/store core. Software sees sixteen registers, selected by a 4-bit index. Behind them sit thirty stored 32-bit registers and a program-counter path, which make thirty-one in all. A 5-bit mode code chooses which stored copy each index reaches.

Indices 0 to 7 reach the same copy in every mode. Indices 8 to 12 have a second copy that only fast-interrupt mode uses. Indices 13 and 14 are the stack pointer and the link register. Each exception mode has its own pair of these, while user and system modes share one pair.

Two read ports are combinational. One write port is synchronous, and a separate strobe loads the link register on a branch-with-link. A force-user input makes privileged transfers reach the user bank. A read of index 15 returns the executing instruction's address plus 8. A write to index 15 becomes a branch request on the outputs.

Top module: `banked_regfile`

## Requirements
- R1: After reset every stored register reads 0, `br_valid_o` is 0, and with a legal mode `illegal_mode_o` is 0.
- R2: Indices 0 to 7 reach one shared copy in all modes. Both read ports return it independently.
- R3: Indices 8 to 12 have a private copy in fast-interrupt mode (10001). Every other legal mode uses the user copy.
- R4: Indices 13 and 14 have private copies in each of fast-interrupt (10001), interrupt (10010), supervisor (10011), abort (10111) and undefined (11011) modes. User (10000) and system (11111) modes share one copy.
- R5: A read of index 15 on either port returns `cur_pc_i + 8` in the same cycle.
- R6: Writes take effect at the rising clock edge. A read of the register being written in that cycle returns the old value.
- R7: A write to index 15 leaves the stored registers unchanged. In the next cycle `br_valid_o` is 1 for exactly one cycle, and `br_target_o` equals the written data with bits [1:0] cleared.
- R8: `link_en_i` loads `link_addr_i` into index 14 of the current bank. It takes priority over an ordinary write to index 14 in the same cycle.
- R9: With `force_user_i` at 1, reads and writes use the user/system bank whatever the mode.
- R10: A mode code outside the seven listed sets `illegal_mode_o`. It blocks file writes, link writes and branch requests, and it maps reads to the user bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 5 | Processor mode code |
| force_user_i | input | 1 | Use the user bank for reads and writes |
| cur_pc_i | input | 32 | Address of the executing instruction |
| rd_a_idx_i | input | 4 | Read port A index |
| rd_a_data_o | output | 32 | Read port A data |
| rd_b_idx_i | input | 4 | Read port B index |
| rd_b_data_o | output | 32 | Read port B data |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | 4 | Write index |
| wr_data_i | input | 32 | Write data |
| link_en_i | input | 1 | Link-register write strobe |
| link_addr_i | input | 32 | Return address to store in index 14 |
| br_valid_o | output | 1 | One-cycle branch request |
| br_target_o | output | 32 | Branch target, word aligned |
| illegal_mode_o | output | 1 | Mode code not recognised |

## Verification
The assertions check a set of properties on every cycle:
- an index-15 read returns the address offset of R5;
- a write to index 15 gives exactly a one-cycle branch pulse with an aligned target;
- a write to a low index is visible from any mode in the following cycle;
- an illegal mode raises no branch and leaves read data unchanged.

Bank separation is covered only by the bench's scenarios:
- which copy each exception mode reaches for indices 8 to 14;
- the link-strobe priority;
- the force-user override.

The bench writes a value in one mode and reads it back in another.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  localparam int PHYS_W   = 5;
  localparam int NUM_PHYS = 30;  // stored copies; PC path makes 31

  localparam logic [4:0] MODE_USR = 5'b10000;
  localparam logic [4:0] MODE_FIQ = 5'b10001;
  localparam logic [4:0] MODE_IRQ = 5'b10010;
  localparam logic [4:0] MODE_SVC = 5'b10011;
  localparam logic [4:0] MODE_ABT = 5'b10111;
  localparam logic [4:0] MODE_UND = 5'b11011;
  localparam logic [4:0] MODE_SYS = 5'b11111;

  typedef enum logic [2:0] {
    BANK_USR, BANK_FIQ, BANK_IRQ, BANK_SVC, BANK_ABT, BANK_UND
  } bank_e;

  // Physical slot layout:
  //   0..14  common + user/system
  //   15..21 fast-interrupt 8..14
  //   22/23  interrupt 13/14
  //   24/25  supervisor 13/14
  //   26/27  abort 13/14
  //   28/29  undefined 13/14
  function automatic logic [PHYS_W-1:0] phys_sel(input bank_e b, input logic [3:0] idx);
    logic [PHYS_W-1:0] ix;
    ix = {1'b0, idx};
    if (idx == 4'd15) return '0;
    if (idx < 4'd8) return ix;
    if (idx < 4'd13) return (b == BANK_FIQ) ? ix + 5'd7 : ix;
    case (b)
      BANK_FIQ: return ix + 5'd7;
      BANK_IRQ: return ix + 5'd9;
      BANK_SVC: return ix + 5'd11;
      BANK_ABT: return ix + 5'd13;
      BANK_UND: return ix + 5'd15;
      default:  return ix;
    endcase
  endfunction
endpackage

// File: rtl/rf_mode_decode.sv
module rf_mode_decode
  import regfile_pkg::*;
(
  input  logic [4:0] mode_i,
  input  logic       force_user_i,
  output bank_e      bank_o,
  output logic       illegal_o
);
  bank_e raw_bank;

  always_comb begin
    illegal_o = 1'b0;
    raw_bank  = BANK_USR;
    case (mode_i)
      MODE_USR, MODE_SYS: raw_bank = BANK_USR;
      MODE_FIQ:           raw_bank = BANK_FIQ;
      MODE_IRQ:           raw_bank = BANK_IRQ;
      MODE_SVC:           raw_bank = BANK_SVC;
      MODE_ABT:           raw_bank = BANK_ABT;
      MODE_UND:           raw_bank = BANK_UND;
      default:            illegal_o = 1'b1;
    endcase
    bank_o = (force_user_i || illegal_o) ? BANK_USR : raw_bank;
  end
endmodule

// File: rtl/rf_store.sv
module rf_store
  import regfile_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PHYS_W-1:0] wsel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] regs_o [NUM_PHYS]
);
  for (genvar g = 0; g < NUM_PHYS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 regs_o[g] <= '0;
      else if (we_i && wsel_i == PHYS_W'(g))       regs_o[g] <= wdata_i;
    end
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
  import regfile_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int PC_AHEAD = 8
) (
  input  logic [DATA_W-1:0] regs_i [NUM_PHYS],
  input  bank_e             bank_i,
  input  logic [3:0]        idx_i,
  input  logic [DATA_W-1:0] pc_i,
  output logic [DATA_W-1:0] data_o
);
  logic [PHYS_W-1:0] sel;

  always_comb begin
    sel = phys_sel(bank_i, idx_i);
    if (idx_i == 4'd15) data_o = pc_i + DATA_W'(PC_AHEAD);
    else                data_o = regs_i[sel];
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import regfile_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int PC_AHEAD = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [4:0]        mode_i,
  input  logic              force_user_i,
  input  logic [DATA_W-1:0] cur_pc_i,
  input  logic [3:0]        rd_a_idx_i,
  output logic [DATA_W-1:0] rd_a_data_o,
  input  logic [3:0]        rd_b_idx_i,
  output logic [DATA_W-1:0] rd_b_data_o,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              link_en_i,
  input  logic [DATA_W-1:0] link_addr_i,
  output logic              br_valid_o,
  output logic [DATA_W-1:0] br_target_o,
  output logic              illegal_mode_o
);
  localparam int NUM_RD = 2;

  bank_e             bank;
  logic              illegal;
  logic              file_we, link_we, br_req;
  logic [PHYS_W-1:0] wsel;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] regs [NUM_PHYS];
  logic [3:0]        rd_idx  [NUM_RD];
  logic [DATA_W-1:0] rd_data [NUM_RD];

  rf_mode_decode u_dec (
    .mode_i      (mode_i),
    .force_user_i(force_user_i),
    .bank_o      (bank),
    .illegal_o   (illegal)
  );

  // link strobe wins over an ordinary write
  always_comb begin
    link_we = link_en_i && !illegal;
    file_we = wr_en_i && (wr_idx_i != 4'd15) && !illegal;
    br_req  = wr_en_i && (wr_idx_i == 4'd15) && !illegal;
    wsel    = link_we ? phys_sel(bank, 4'd14) : phys_sel(bank, wr_idx_i);
    wdata   = link_we ? link_addr_i : wr_data_i;
  end

  rf_store #(.DATA_W(DATA_W)) u_store (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (link_we || file_we),
    .wsel_i (wsel),
    .wdata_i(wdata),
    .regs_o (regs)
  );

  assign rd_idx[0] = rd_a_idx_i;
  assign rd_idx[1] = rd_b_idx_i;

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    rf_read_port #(.DATA_W(DATA_W), .PC_AHEAD(PC_AHEAD)) u_rd (
      .regs_i(regs),
      .bank_i(bank),
      .idx_i (rd_idx[p]),
      .pc_i  (cur_pc_i),
      .data_o(rd_data[p])
    );
  end

  assign rd_a_data_o = rd_data[0];
  assign rd_b_data_o = rd_data[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      br_valid_o  <= 1'b0;
      br_target_o <= '0;
    end else begin
      br_valid_o <= br_req;
      if (br_req) br_target_o <= {wr_data_i[DATA_W-1:2], 2'b00};
    end
  end

  assign illegal_mode_o = illegal;
endmodule

// File: rtl/regfile_checker.sv
module regfile_checker #(
  parameter int DATA_W   = 32,
  parameter int PC_AHEAD = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [4:0]        mode_i,
  input logic              force_user_i,
  input logic [DATA_W-1:0] cur_pc_i,
  input logic [3:0]        rd_a_idx_i,
  input logic [DATA_W-1:0] rd_a_data_o,
  input logic [3:0]        rd_b_idx_i,
  input logic [DATA_W-1:0] rd_b_data_o,
  input logic              wr_en_i,
  input logic [3:0]        wr_idx_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              link_en_i,
  input logic [DATA_W-1:0] link_addr_i,
  input logic              br_valid_o,
  input logic [DATA_W-1:0] br_target_o,
  input logic              illegal_mode_o
);
  assert_pc_ahead_a_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_a_idx_i == 4'd15 |-> rd_a_data_o == cur_pc_i + DATA_W'(PC_AHEAD));

  assert_pc_ahead_b_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_b_idx_i == 4'd15 |-> rd_b_data_o == cur_pc_i + DATA_W'(PC_AHEAD));

  assert_branch_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i == 4'd15 && !illegal_mode_o)
      |=> br_valid_o && br_target_o == {$past(wr_data_i[DATA_W-1:2]), 2'b00});

  assert_no_spurious_branch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_idx_i == 4'd15) |=> !br_valid_o);

  assert_illegal_no_branch_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_mode_o |=> !br_valid_o);

  assert_illegal_reads_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (illegal_mode_o && $past(illegal_mode_o) && $stable(rd_a_idx_i) && rd_a_idx_i != 4'd15)
      |-> $stable(rd_a_data_o));

  assert_low_shared_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i < 4'd8 && !illegal_mode_o && !link_en_i)
      |=> (rd_a_idx_i != $past(wr_idx_i) || rd_a_data_o == $past(wr_data_i)));
endmodule

bind banked_regfile regfile_checker #(.DATA_W(DATA_W), .PC_AHEAD(PC_AHEAD)) u_chk (.*);

// File: tb/banked_regfile_test.sv
`timescale 1ns/1ps
module banked_regfile_test;
  localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                         SVC = 5'b10011, ABT = 5'b10111, UND = 5'b11011,
                         SYS = 5'b11111, BAD = 5'b10100;
  localparam logic [31:0] PC = 32'h0000_0100;

  typedef struct packed {
    logic [15:0] req;
    logic [4:0]  wm;
    logic [3:0]  wi;
    logic [31:0] wd;
    logic [4:0]  rm;
    logic [3:0]  ri;
    logic [31:0] ex;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{"R2", USR, 4'd3,  32'hA1, FIQ, 4'd3,  32'hA1},
    '{"R2", SVC, 4'd7,  32'hB2, UND, 4'd7,  32'hB2},
    '{"R3", USR, 4'd8,  32'hC3, FIQ, 4'd8,  32'h0},
    '{"R3", FIQ, 4'd8,  32'hD4, USR, 4'd8,  32'hC3},
    '{"R3", FIQ, 4'd10, 32'hE5, FIQ, 4'd10, 32'hE5},
    '{"R4", IRQ, 4'd13, 32'h1111, SVC, 4'd13, 32'h0},
    '{"R4", SVC, 4'd13, 32'h2222, IRQ, 4'd13, 32'h1111},
    '{"R4", ABT, 4'd14, 32'h3333, UND, 4'd14, 32'h0},
    '{"R4", SYS, 4'd13, 32'h4444, USR, 4'd13, 32'h4444},
    '{"R3", IRQ, 4'd9,  32'h5555, USR, 4'd9,  32'h5555},
    '{"R4", UND, 4'd14, 32'h6666, ABT, 4'd14, 32'h3333},
    '{"R5", USR, 4'd0,  32'h7777, SYS, 4'd15, PC + 32'd8}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [4:0]  mode = USR;
  logic        force_user = 1'b0;
  logic [31:0] cur_pc = PC;
  logic [3:0]  ra = '0, rb = '0, widx = '0;
  logic [31:0] rda, rdb, wdata = '0, link_addr = '0, br_target;
  logic        we = 1'b0, link_en = 1'b0, br_valid, illegal;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  banked_regfile uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .force_user_i(force_user),
    .cur_pc_i(cur_pc), .rd_a_idx_i(ra), .rd_a_data_o(rda), .rd_b_idx_i(rb),
    .rd_b_data_o(rdb), .wr_en_i(we), .wr_idx_i(widx), .wr_data_i(wdata),
    .link_en_i(link_en), .link_addr_i(link_addr), .br_valid_o(br_valid),
    .br_target_o(br_target), .illegal_mode_o(illegal)
  );

  task automatic check(input string req, input string what, input logic [31:0] got,
                       input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] m, input logic [3:0] i, input logic [31:0] d);
    @(negedge clk);
    mode = m; widx = i; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] m, input logic [3:0] i, output logic [31:0] d);
    @(negedge clk);
    mode = m; ra = i; rb = i;
    #1 d = rda;
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    ra = 4'd5; rb = 4'd12; #1;
    check("R1", "reset r5", rda, 32'h0);
    check("R1", "reset r12", rdb, 32'h0);
    check("R1", "reset br_valid", {31'b0, br_valid}, 32'h0);
    check("R1", "reset illegal", {31'b0, illegal}, 32'h0);
    @(negedge clk) rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      wr(VECS[k].wm, VECS[k].wi, VECS[k].wd);
      rd(VECS[k].rm, VECS[k].ri, v);
      check(string'(VECS[k].req), $sformatf("table[%0d] port A", k), v, VECS[k].ex);
      check(string'(VECS[k].req), $sformatf("table[%0d] port B", k), rdb, VECS[k].ex);
    end

    // R6 same-cycle read returns old value
    @(negedge clk);
    mode = USR; widx = 4'd2; wdata = 32'hAA; we = 1'b1; ra = 4'd2;
    #1 check("R6", "read during write", rda, 32'h0);
    @(negedge clk); we = 1'b0; #1;
    check("R6", "read after edge", rda, 32'hAA);

    // R7 write to index 15 -> branch pulse
    @(negedge clk);
    mode = USR; widx = 4'd15; wdata = 32'h1003; we = 1'b1; ra = 4'd15;
    @(negedge clk); we = 1'b0; #1;
    check("R7", "br_valid set", {31'b0, br_valid}, 32'h1);
    check("R7", "br_target aligned", br_target, 32'h1000);
    check("R7", "r15 still pc+8", rda, PC + 32'd8);
    @(negedge clk); #1;
    check("R7", "br_valid one cycle", {31'b0, br_valid}, 32'h0);

    // R8 link strobe
    @(negedge clk);
    mode = SVC; link_addr = 32'h2004; link_en = 1'b1;
    @(negedge clk); link_en = 1'b0;
    rd(SVC, 4'd14, v); check("R8", "svc r14 link", v, 32'h2004);
    rd(USR, 4'd14, v); check("R8", "usr r14 untouched", v, 32'h0);
    @(negedge clk);
    mode = SVC; link_addr = 32'h2008; link_en = 1'b1;
    widx = 4'd14; wdata = 32'h9; we = 1'b1;
    @(negedge clk); link_en = 1'b0; we = 1'b0;
    rd(SVC, 4'd14, v); check("R8", "link wins over write", v, 32'h2008);

    // R9 force-user override
    @(negedge clk); force_user = 1'b1;
    wr(FIQ, 4'd8, 32'hF0);
    rd(FIQ, 4'd8, v); check("R9", "forced read fiq r8", v, 32'hF0);
    @(negedge clk); force_user = 1'b0;
    rd(USR, 4'd8, v); check("R9", "user r8 overwritten", v, 32'hF0);
    rd(FIQ, 4'd8, v); check("R9", "fiq r8 kept", v, 32'hD4);

    // R10 illegal mode
    rd(BAD, 4'd13, v);
    check("R10", "illegal flag", {31'b0, illegal}, 32'h1);
    check("R10", "illegal reads user r13", v, 32'h4444);
    wr(BAD, 4'd1, 32'hBAD);
    @(negedge clk);
    mode = BAD; link_addr = 32'h55; link_en = 1'b1;
    @(negedge clk); link_en = 1'b0;
    @(negedge clk);
    mode = BAD; widx = 4'd15; wdata = 32'h4000; we = 1'b1;
    @(negedge clk); we = 1'b0; #1;
    check("R10", "no branch when illegal", {31'b0, br_valid}, 32'h0);
    rd(USR, 4'd1, v); check("R10", "write blocked", v, 32'h0);
    rd(USR, 4'd14, v); check("R10", "link blocked", v, 32'h0);

    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule